// File: doc/BRIEF.md
# Line-Driver Front-End SPI Write Slave

This block is the digital receiving side of a transmit line-driver. A host writes to it over a three-wire, write-only SPI link made of chip select, serial clock and data in. A separate steering input picks the destination of each frame. When the steering input is high, the frame goes to a small file of control registers. When it is low, the frame goes to the holding register of a 10-bit DAC. No data is read back.

A frame opens when chip select falls and closes when it rises. Data is captured on the rising edges of the serial clock, most significant bit first, and a valid frame holds exactly sixteen bits. The DAC word and the registers change only when chip select rises at the end of a valid frame. The host therefore sets the sample rate through the chip-select period. The serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are detected in the system clock domain. The serial clock must stay at each level for at least three system clocks.

The decoded outputs are a DAC-mode enable, a power-amplifier enable, a two-bit transmit gain code and a two-bit filter band code. Downstream analog logic uses these outputs.

Top module: `txfe_spi_slave`

## Requirements
- R1: After reset, dac_word, dac_mode_en, pa_en, tx_gain and filt_band are all zero.
- R2: A DAC frame holds exactly 16 bits, sent MSB first. The last 10 bits received become dac_word, and the first 6 bits are ignored.
- R3: dac_word changes only when chip select rises. A new value appears on the third system clock edge after spi_cs_n goes high and is not visible before that edge.
- R4: In a register frame the first byte is an address and the second byte is data, and dac_word does not change.
- R5: A write to address 0x01 sets dac_mode_en from data bit 5 and pa_en from data bit 0. The other bits of the data byte are ignored.
- R6: A write to address 0x02 sets tx_gain to data bits [1:0]. The codes are 00 = 0.25, 01 = 0.5, 10 = 0.707 and 11 = 1 V/V, and the last write wins.
- R7: A write to address 0x03 sets filt_band to data bits [1:0]. The codes are 00 = band B, 01 = band C and 10 = band D. Code 11 is ignored, so filt_band keeps its value.
- R8: A register frame to any other address changes no output.
- R9: A frame with fewer or more than 16 bits is discarded, and no output changes.
- R10: route_sel is taken when chip select falls, so changing it later in the frame has no effect. Serial clock edges while chip select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, data captured on its rising edge |
| spi_mosi | input | 1 | Serial data in |
| route_sel | input | 1 | 1 = control registers, 0 = DAC |
| dac_word | output | 10 | DAC holding register |
| dac_mode_en | output | 1 | DAC drives the transmit gain stage |
| pa_en | output | 1 | Power-amplifier output enable |
| tx_gain | output | 2 | Transmit gain code |
| filt_band | output | 2 | Transmit filter band code |

## Verification
Every result of this block is due on the third system clock edge after spi_cs_n rises. There are two synchroniser stages, and the commit happens on the edge that sees the detected rise. The bench drives all inputs on falling clock edges. For the commit timing it samples at the falling edge after the second rising edge, where the old value must still be present, and again after the third rising edge, where the new value must be present. For all other frames it waits six cycles after chip select rises before comparing every output with its bench model. That wait is also the point at which a discarded, rejected or ignored frame is shown to have left the outputs unchanged.

// File: rtl/txfe_pkg.sv
package txfe_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [7:0] ADDR_ENABLE = 8'h01;
    localparam logic [7:0] ADDR_GAIN   = 8'h02;
    localparam logic [7:0] ADDR_BAND   = 8'h03;

    localparam int BIT_DAC_MODE = 5;
    localparam int BIT_PA_EN    = 0;

    localparam logic [1:0] BAND_RESERVED = 2'b11;
endpackage

// File: rtl/txfe_sync.sv
module txfe_sync #(
    parameter int         W      = 4,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stage_d;
        if (s == 0) begin : g_first
            always_comb stage_d = din;
        end else begin : g_next
            always_comb stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST;
            else        stage_q[s] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/txfe_frame_rx.sv
module txfe_frame_rx
    import txfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  mosi_s,
    input  logic                  route_s,
    output logic                  frame_ok,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_route
);
    typedef struct packed {
        logic                  sclk_prev;
        logic                  cs_prev;
        logic                  in_frame;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic                  route;
    } rx_t;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    rx_t st_d, st_q;
    logic cs_fall, cs_rise, sclk_rise;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_s;
        cs_fall        = !cs_s && st_q.cs_prev;
        cs_rise        = cs_s && !st_q.cs_prev;
        sclk_rise      = sclk_s && !st_q.sclk_prev;
        if (cs_fall) begin
            st_d.in_frame = 1'b1;
            st_d.cnt      = '0;
            st_d.route    = route_s;
        end else if (cs_rise) begin
            st_d.in_frame = 1'b0;
        end else if (st_q.in_frame && sclk_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], mosi_s};
            if (st_q.cnt != CNT_OVER) st_d.cnt = st_q.cnt + 1'b1;
        end
        frame_ok = cs_rise && st_q.in_frame && (st_q.cnt == CNT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_data  = st_q.shreg;
    assign frame_route = st_q.route;

    // R10: the steering choice is frozen for the whole frame
    a_r10_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_frame && cs_s == 1'b0 && st_q.cs_prev == 1'b0) |=> $stable(st_q.route));

    // R10: serial clock activity outside a frame leaves the bit count alone
    a_r10_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.in_frame && cs_s && st_q.cs_prev) |=> $stable(st_q.cnt));
endmodule

// File: rtl/txfe_regs.sv
module txfe_regs
    import txfe_pkg::*;
#(
    parameter int DAC_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic [FRAME_BITS-1:0] frame_data,
    input  logic                  frame_route,
    output logic [DAC_W-1:0]      dac_word,
    output logic                  dac_mode_en,
    output logic                  pa_en,
    output logic [1:0]            tx_gain,
    output logic [1:0]            filt_band
);
    typedef struct packed {
        logic [DAC_W-1:0] dac;
        logic             dac_mode;
        logic             pa;
        logic [1:0]       gain;
        logic [1:0]       band;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [7:0] addr, wdata;

    always_comb begin
        rg_d  = rg_q;
        addr  = frame_data[15:8];
        wdata = frame_data[7:0];
        if (frame_ok) begin
            if (!frame_route) begin
                rg_d.dac = frame_data[DAC_W-1:0];
            end else begin
                case (addr)
                    ADDR_ENABLE: begin
                        rg_d.dac_mode = wdata[BIT_DAC_MODE];
                        rg_d.pa       = wdata[BIT_PA_EN];
                    end
                    ADDR_GAIN: rg_d.gain = wdata[1:0];
                    ADDR_BAND: if (wdata[1:0] != BAND_RESERVED) rg_d.band = wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign dac_word    = rg_q.dac;
    assign dac_mode_en = rg_q.dac_mode;
    assign pa_en       = rg_q.pa;
    assign tx_gain     = rg_q.gain;
    assign filt_band   = rg_q.band;

    // R9: without a completed frame nothing moves
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable({dac_word, dac_mode_en, pa_en, tx_gain, filt_band}));

    // R4: register frames never touch the DAC word
    a_r4_dac_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && frame_route) |=> $stable(dac_word));

    // R7: the reserved band code can never be held
    a_r7_band_legal: assert property (@(posedge clk) disable iff (!rst_n)
        filt_band != BAND_RESERVED);
endmodule

// File: rtl/txfe_spi_slave.sv
module txfe_spi_slave
    import txfe_pkg::*;
#(
    parameter int DAC_W     = 10,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    input  logic             route_sel,
    output logic [DAC_W-1:0] dac_word,
    output logic             dac_mode_en,
    output logic             pa_en,
    output logic [1:0]       tx_gain,
    output logic [1:0]       filt_band
);
    logic [3:0] raw_in, sync_out;
    logic frame_ok, frame_route;
    logic [FRAME_BITS-1:0] frame_data;

    assign raw_in = {route_sel, spi_mosi, spi_sclk, spi_cs_n};

    txfe_sync #(.W(4), .STAGES(SYNC_DEPTH), .RST(4'b0001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    txfe_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (sync_out[0]),
        .sclk_s     (sync_out[1]),
        .mosi_s     (sync_out[2]),
        .route_s    (sync_out[3]),
        .frame_ok   (frame_ok),
        .frame_data (frame_data),
        .frame_route(frame_route)
    );

    txfe_regs #(.DAC_W(DAC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ok   (frame_ok),
        .frame_data (frame_data),
        .frame_route(frame_route),
        .dac_word   (dac_word),
        .dac_mode_en(dac_mode_en),
        .pa_en      (pa_en),
        .tx_gain    (tx_gain),
        .filt_band  (filt_band)
    );
endmodule

// File: tb/sim_txfe_spi_slave.sv
module sim_txfe_spi_slave;
    logic clk = 0, rst_n = 0;
    logic cs_n = 1, sclk = 0, mosi = 0, route = 0;
    logic [9:0] dac_word;
    logic dac_mode_en, pa_en;
    logic [1:0] tx_gain, filt_band;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [9:0] e_dac = 0;
    logic e_mode = 0, e_pa = 0;
    logic [1:0] e_gain = 0, e_band = 0;

    always #4 clk = ~clk;

    txfe_spi_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .route_sel(route), .dac_word(dac_word),
        .dac_mode_en(dac_mode_en), .pa_en(pa_en), .tx_gain(tx_gain),
        .filt_band(filt_band)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " dac_word"}, 32'(dac_word), 32'(e_dac));
        chk({tag, " dac_mode_en"}, 32'(dac_mode_en), 32'(e_mode));
        chk({tag, " pa_en"}, 32'(pa_en), 32'(e_pa));
        chk({tag, " tx_gain"}, 32'(tx_gain), 32'(e_gain));
        chk({tag, " filt_band"}, 32'(filt_band), 32'(e_band));
    endtask

    function automatic void model(input logic r, input logic [15:0] d, input int nb);
        if (nb != 16) return;
        if (!r) e_dac = d[9:0];
        else case (d[15:8])
            8'h01: begin e_mode = d[5]; e_pa = d[0]; end
            8'h02: e_gain = d[1:0];
            8'h03: if (d[1:0] != 2'b11) e_band = d[1:0];
            default: ;
        endcase
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // flip: invert route_sel after chip select has been seen low
    task automatic send(input logic r, input logic [15:0] d, input int nb, input bit flip);
        @(negedge clk);
        route = r;
        wclk(1);
        cs_n = 0;
        wclk(4);
        if (flip) route = ~r;
        for (int i = 0; i < nb; i++) begin
            mosi = (i < 16) ? d[15-i] : 1'b1;
            sclk = 0; wclk(4);
            sclk = 1; wclk(4);
        end
        sclk = 0; wclk(4);
        cs_n = 1;
    endtask

    task automatic frame(input string tag, input logic r, input logic [15:0] d, input int nb, input bit flip);
        send(r, d, nb, flip);
        model(r, d, nb);
        wclk(6);
        chk_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic r;
        int nb;
        void'($urandom(32'd1234));
        wclk(3);
        chk_all("R1 reset");
        rst_n = 1;
        wclk(3);
        chk_all("R1 after release");

        // R2: upper six bits ignored
        frame("R2 dac", 1'b0, 16'hFE5A, 16, 0);
        frame("R2 dac low", 1'b0, 16'h0001, 16, 0);

        // R3: commit timing after chip select rises
        send(1'b0, 16'h02A7, 16, 0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R3 before commit", 32'(dac_word), 32'(e_dac));
        model(1'b0, 16'h02A7, 16);
        @(posedge clk); @(negedge clk);
        chk("R3 at commit", 32'(dac_word), 32'h2A7);
        wclk(4);

        // R5/R6/R7
        frame("R5 enable", 1'b1, 16'h01FF, 16, 0);
        frame("R5 enable bits only", 1'b1, 16'h01DE, 16, 0);
        frame("R6 gain", 1'b1, 16'h0203, 16, 0);
        frame("R6 gain rewrite", 1'b1, 16'h02FE, 16, 0);
        frame("R7 band D", 1'b1, 16'h0302, 16, 0);
        frame("R7 band reserved", 1'b1, 16'h0303, 16, 0);
        frame("R4 reg frame keeps dac", 1'b1, 16'h0301, 16, 0);
        frame("R8 unknown addr", 1'b1, 16'h7F00, 16, 0);
        frame("R8 addr zero", 1'b1, 16'h00FF, 16, 0);

        // R9: short and long frames discarded
        frame("R9 short", 1'b0, 16'h0155, 15, 0);
        frame("R9 long", 1'b0, 16'h0133, 17, 0);
        frame("R9 short reg", 1'b1, 16'h0200, 12, 0);

        // R10: late route change and idle clocks
        frame("R10 route kept dac", 1'b0, 16'h0203, 16, 1);
        frame("R10 route kept reg", 1'b1, 16'h0100, 16, 1);
        for (int i = 0; i < 8; i++) begin
            mosi = i[0]; sclk = 1; wclk(4); sclk = 0; wclk(4);
        end
        chk_all("R10 idle sclk");
        frame("R10 frame after idle", 1'b0, 16'h0321, 16, 0);

        // random mix
        for (int k = 0; k < 80; k++) begin
            r = 1'($urandom);
            d = 16'($urandom);
            case ($urandom % 4)
                0: d[15:8] = 8'h01;
                1: d[15:8] = 8'h02;
                2: d[15:8] = 8'h03;
                default: ;
            endcase
            nb = ($urandom % 6 == 0) ? (($urandom % 2) ? 15 : 17) : 16;
            frame(nb == 16 ? (r ? "R4 random reg" : "R2 random dac") : "R9 random bad length",
                  r, d, nb, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule